// File: doc/BRIEF.md
# Serial Frame Transmitter with Half-Duplex Line Drive Control

This block is the transmit side of an asynchronous serial port meant for a shared two-wire bus. It takes characters from an external first-word-fall-through queue, which the surrounding logic owns, and sends each one as a frame on a serial line. The frame is a low start bit, 5 to 8 data bits sent least significant bit first, an optional even or odd parity bit, and one or two high stop bits. The bit period is a run-time divisor counted in system clocks.

The block also drives an enable for the external line driver of a half-duplex transceiver. The enable rises one full bit period before the first start bit, so the driver has time to settle on the bus. It stays up while more queued characters follow back to back. It drops only once the final stop bit has fully elapsed. Frame format and divisor are captured when a character is taken from the queue, so changes made by the host never corrupt a frame that is already in flight. A transmitter-empty flag tells the host when the queue and the shifter are both idle.

Top module: `uart485_tx`

## Requirements
- R1: After reset, and whenever nothing is queued or in flight, `txd` is high, `line_drive_en` is low and `fifo_rd` is low.
- R2: A frame is a low start bit, then the data bits least significant first, then the parity bit if enabled, then the stop bits (high). Every bit, the lead bit included, lasts exactly D clocks, where D is the captured divisor.
- R3: `word_sel` sets the data length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Unused upper bits of `fifo_data` are not sent.
- R4: `parity_mode` code 1 appends an even-parity bit, so the data ones plus the parity bit are even. Code 2 appends an odd-parity bit. Codes 0 and 3 send no parity bit.
- R5: `two_stop` low sends one stop bit and high sends two.
- R6: A `baud_div` of 0 behaves exactly as a divisor of 1, which gives one clock per bit.
- R7: When the block leaves idle, `line_drive_en` rises on the same edge that takes the character. The line then stays high for exactly one bit period (the lead bit) before the start bit.
- R8: If the queue is non-empty in the last clock of a frame's final stop bit, the next start bit follows at once with no lead bit. `line_drive_en` stays high across the gap.
- R9: `line_drive_en` falls only on the edge that ends the final stop bit of a frame when the queue is empty. On that same edge the line returns to idle.
- R10: `tmt` is high exactly when `fifo_empty` is high and no frame or lead bit is in progress.
- R11: `baud_div`, `word_sel`, `two_stop` and `parity_mode` are sampled only on the clock that takes a character from the queue. Changes during a frame affect only later frames.
- R12: `fifo_rd` is a one-clock pulse, never asserted while `fifo_empty` is high. It is asserted in an idle clock with data waiting, or in the last clock of the final stop bit with data waiting, and nowhere else.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_div | input | DIV_W | Clocks per serial bit (0 treated as 1) |
| word_sel | input | 2 | Data length select: 0..3 gives 5..8 bits |
| two_stop | input | 1 | 1 selects two stop bits |
| parity_mode | input | 2 | 0/3 none, 1 even, 2 odd |
| fifo_data | input | 8 | Head word of the transmit queue (valid while not empty) |
| fifo_empty | input | 1 | Transmit queue has no word |
| fifo_rd | output | 1 | Pop strobe for the transmit queue |
| txd | output | 1 | Serial line, idles high |
| line_drive_en | output | 1 | Enable for the external transceiver's line driver |
| tmt | output | 1 | Queue empty and transmitter idle |

## Verification
The hardest case to reach from the ports is the handover in the last clock of a stop bit. There, the next character must be taken and its start bit begun with no lead bit and no drop of the driver enable. A one-clock slip in either direction would fall silently between two frames. The bench reaches it by queuing several characters together and by pushing a further character while a frame is already in flight. It also changes the format and divisor mid-frame with a character waiting, so the handover edge captures a new format. The reference model expands each character into an expected per-clock waveform from the format it held when taken. It compares line, enable, pop strobe and empty flag on every clock.

// File: rtl/uart485_pkg.sv
package uart485_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LEAD  = 3'd1,
    ST_START = 3'd2,
    ST_DATA  = 3'd3,
    ST_PAR   = 3'd4,
    ST_STOP  = 3'd5
  } tx_state_e;

  typedef enum logic [1:0] {
    PAR_OFF  = 2'd0,
    PAR_EVEN = 2'd1,
    PAR_ODD  = 2'd2,
    PAR_OFF2 = 2'd3
  } par_mode_e;

  typedef struct packed {
    logic [1:0] wsel;
    logic       two_stop;
    par_mode_e  par;
  } frame_cfg_t;

  // Keeps only the bits that belong to the selected word length.
  function automatic logic [7:0] word_mask(input logic [1:0] wsel);
    return 8'hFF >> (2'd3 - wsel);
  endfunction

  // Index of the final data bit for the selected word length.
  function automatic logic [2:0] last_bit(input logic [1:0] wsel);
    return 3'd4 + {1'b0, wsel};
  endfunction

  function automatic logic par_enabled(input par_mode_e p);
    return (p == PAR_EVEN) || (p == PAR_ODD);
  endfunction
endpackage

// File: rtl/u485_baud_timer.sv
module u485_baud_timer #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_in,
  input  logic             capture,
  input  logic             restart,
  output logic             bit_done
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] div_lat;
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] div_eff;

  assign div_eff  = (div_in == '0) ? ONE : div_in;
  assign bit_done = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_lat <= ONE;
      cnt     <= '0;
    end else if (capture) begin
      div_lat <= div_eff;
      cnt     <= div_eff - ONE;
    end else if (restart) begin
      cnt <= div_lat - ONE;
    end else if (cnt != '0) begin
      cnt <= cnt - ONE;
    end
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (cnt < div_lat)); // R6

  AST_DIV_NONZERO_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    capture |=> (div_lat != '0)); // R6
endmodule

// File: rtl/u485_frame_seq.sv
module u485_frame_seq
  import uart485_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  frame_cfg_t cfg_in,
  input  logic [7:0] fifo_data,
  input  logic       fifo_empty,
  input  logic       bit_done,
  output logic       pop,
  output logic       launch,
  output logic       finish,
  output logic       restart,
  output logic       busy,
  output logic       txd
);
  timeunit 1ns;
  timeprecision 1ps;

  tx_state_e  state;
  frame_cfg_t cfg_lat;
  logic [7:0] shreg;
  logic [2:0] bit_idx;
  logic       stop_idx;
  logic       par_bit;
  logic       bit_end;
  logic       last_stop;
  logic [7:0] new_word;

  assign busy      = (state != ST_IDLE);
  assign bit_end   = bit_done && busy;
  assign last_stop = (state == ST_STOP) && bit_end && (stop_idx == cfg_lat.two_stop);
  assign launch    = (state == ST_IDLE) && !fifo_empty;
  assign finish    = last_stop && fifo_empty;
  assign pop       = launch || (last_stop && !fifo_empty);
  assign restart   = bit_end && !pop;
  assign new_word  = fifo_data & word_mask(cfg_in.wsel);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      txd      <= 1'b1;
      cfg_lat  <= '0;
      shreg    <= '0;
      bit_idx  <= '0;
      stop_idx <= 1'b0;
      par_bit  <= 1'b0;
    end else if (pop) begin
      cfg_lat  <= cfg_in;
      shreg    <= new_word;
      par_bit  <= (^new_word) ^ (cfg_in.par == PAR_ODD);
      bit_idx  <= '0;
      stop_idx <= 1'b0;
      if (state == ST_IDLE) begin
        state <= ST_LEAD;
        txd   <= 1'b1;
      end else begin
        state <= ST_START;
        txd   <= 1'b0;
      end
    end else if (bit_end) begin
      case (state)
        ST_LEAD: begin
          state <= ST_START;
          txd   <= 1'b0;
        end
        ST_START: begin
          state <= ST_DATA;
          txd   <= shreg[0];
        end
        ST_DATA: begin
          if (bit_idx == last_bit(cfg_lat.wsel)) begin
            if (par_enabled(cfg_lat.par)) begin
              state <= ST_PAR;
              txd   <= par_bit;
            end else begin
              state <= ST_STOP;
              txd   <= 1'b1;
            end
          end else begin
            bit_idx <= bit_idx + 3'd1;
            shreg   <= shreg >> 1;
            txd     <= shreg[1];
          end
        end
        ST_PAR: begin
          state <= ST_STOP;
          txd   <= 1'b1;
        end
        ST_STOP: begin
          if (stop_idx == cfg_lat.two_stop) begin
            state <= ST_IDLE;
            txd   <= 1'b1;
          end else begin
            stop_idx <= 1'b1;
          end
        end
        default: begin
          state <= ST_IDLE;
          txd   <= 1'b1;
        end
      endcase
    end
  end

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (busy && !pop) |=> $stable(cfg_lat)); // R11

  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
    pop |-> !fifo_empty); // R12

  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> txd); // R1

  AST_STOP_HIGH: assert property (@(posedge clk) disable iff (rst)
    (state == ST_STOP) |-> txd); // R2
endmodule

// File: rtl/u485_dir_ctl.sv
module u485_dir_ctl (
  input  logic clk,
  input  logic rst,
  input  logic launch,
  input  logic finish,
  output logic drive_en
);
  timeunit 1ns;
  timeprecision 1ps;

  always_ff @(posedge clk) begin
    if (rst) begin
      drive_en <= 1'b0;
    end else if (launch) begin
      drive_en <= 1'b1;
    end else if (finish) begin
      drive_en <= 1'b0;
    end
  end

  AST_LAUNCH_FINISH_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(launch && finish)); // R9

  AST_LAUNCH_FROM_OFF: assert property (@(posedge clk) disable iff (rst)
    launch |-> !drive_en); // R7
endmodule

// File: rtl/uart485_tx.sv
module uart485_tx
  import uart485_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] baud_div,
  input  logic [1:0]       word_sel,
  input  logic             two_stop,
  input  logic [1:0]       parity_mode,
  input  logic [7:0]       fifo_data,
  input  logic             fifo_empty,
  output logic             fifo_rd,
  output logic             txd,
  output logic             line_drive_en,
  output logic             tmt
);
  timeunit 1ns;
  timeprecision 1ps;

  frame_cfg_t cfg_in;
  logic       bit_done;
  logic       pop;
  logic       launch;
  logic       finish;
  logic       restart;
  logic       busy;

  assign cfg_in.wsel     = word_sel;
  assign cfg_in.two_stop = two_stop;
  assign cfg_in.par      = par_mode_e'(parity_mode);

  u485_baud_timer #(.DIV_W(DIV_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .div_in   (baud_div),
    .capture  (pop),
    .restart  (restart),
    .bit_done (bit_done)
  );

  u485_frame_seq u_seq (
    .clk        (clk),
    .rst        (rst),
    .cfg_in     (cfg_in),
    .fifo_data  (fifo_data),
    .fifo_empty (fifo_empty),
    .bit_done   (bit_done),
    .pop        (pop),
    .launch     (launch),
    .finish     (finish),
    .restart    (restart),
    .busy       (busy),
    .txd        (txd)
  );

  u485_dir_ctl u_dir (
    .clk      (clk),
    .rst      (rst),
    .launch   (launch),
    .finish   (finish),
    .drive_en (line_drive_en)
  );

  assign fifo_rd = pop;
  assign tmt     = fifo_empty && !busy;

  AST_LOW_NEEDS_DRIVE: assert property (@(posedge clk) disable iff (rst)
    !txd |-> line_drive_en); // R7

  AST_TMT_QUIET: assert property (@(posedge clk) disable iff (rst)
    tmt |-> (txd && !line_drive_en && !fifo_rd)); // R10

  AST_DRIVE_DROP_HIGH: assert property (@(posedge clk) disable iff (rst)
    $fell(line_drive_en) |-> (txd && $past(txd))); // R9

  AST_RD_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst)
    fifo_rd |=> !fifo_rd); // R12
endmodule

// File: tb/uart485_tx_test.sv
module uart485_tx_test;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] baud_div = 16'd1;
  logic [1:0]  word_sel = 2'd3;
  logic        two_stop = 1'b0;
  logic [1:0]  parity_mode = 2'd0;
  logic [7:0]  fifo_data = 8'h00;
  logic        fifo_empty = 1'b1;
  logic        fifo_rd;
  logic        txd;
  logic        line_drive_en;
  logic        tmt;

  int    checks = 0;
  int    errors = 0;
  bit    done = 0;
  string cur_req = "R1";

  bit         eq[$];   // expected line level per clock of the current activity
  logic [7:0] bq[$];   // model of the external queue

  always #10 clk = ~clk; // 50 MHz

  uart485_tx #(.DIV_W(16)) uut (
    .clk           (clk),
    .rst           (rst),
    .baud_div      (baud_div),
    .word_sel      (word_sel),
    .two_stop      (two_stop),
    .parity_mode   (parity_mode),
    .fifo_data     (fifo_data),
    .fifo_empty    (fifo_empty),
    .fifo_rd       (fifo_rd),
    .txd           (txd),
    .line_drive_en (line_drive_en),
    .tmt           (tmt)
  );

  task automatic check1(input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  // Append the expected waveform of one character (R2, R3, R4, R5, R6, R7).
  task automatic build(input logic [7:0] d, input bit lead);
    int dv;
    int n;
    bit p;
    dv = (baud_div == 16'd0) ? 1 : int'(baud_div);
    n  = 5 + int'(word_sel);
    if (lead) for (int k = 0; k < dv; k++) eq.push_back(1'b1);
    for (int k = 0; k < dv; k++) eq.push_back(1'b0);
    p = 1'b0;
    for (int i = 0; i < n; i++) begin
      p = p ^ d[i];
      for (int k = 0; k < dv; k++) eq.push_back(d[i]);
    end
    if (parity_mode == 2'd1 || parity_mode == 2'd2) begin
      if (parity_mode == 2'd2) p = ~p;
      for (int k = 0; k < dv; k++) eq.push_back(p);
    end
    for (int k = 0; k < (two_stop ? 2 : 1) * dv; k++) eq.push_back(1'b1);
  endtask

  task automatic compare_now();
    bit exp_rd;
    exp_rd = (eq.size() <= 1) && (bq.size() != 0);
    check1("txd", txd, (eq.size() != 0) ? eq[0] : 1'b1);
    check1("line_drive_en", line_drive_en, eq.size() != 0);
    check1("tmt", tmt, (eq.size() == 0) && (bq.size() == 0));   // R10
    check1("fifo_rd", fifo_rd, exp_rd);                          // R12
  endtask

  task automatic step();
    bit popnow;
    bit lead;
    logic [7:0] d;
    @(posedge clk);
    popnow = (eq.size() <= 1) && (bq.size() != 0);
    lead   = (eq.size() == 0);
    if (eq.size() != 0) void'(eq.pop_front());
    if (popnow) begin
      d = bq.pop_front();
      build(d, lead);
    end
    fifo_empty <= (bq.size() == 0);
    fifo_data  <= (bq.size() != 0) ? bq[0] : 8'h00;
    @(negedge clk);
    compare_now();
  endtask

  task automatic push(input logic [7:0] d);
    bq.push_back(d);
    fifo_empty = 1'b0;
    fifo_data  = bq[0];
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic drain();
    int guard;
    guard = 0;
    while ((eq.size() != 0 || bq.size() != 0) && guard < 20000) begin
      step();
      guard++;
    end
    steps(2);
  endtask

  task automatic set_fmt(input logic [15:0] dv, input logic [1:0] ws,
                         input logic ts, input logic [1:0] pm);
    baud_div    = dv;
    word_sel    = ws;
    two_stop    = ts;
    parity_mode = pm;
  endtask

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    cur_req = "R1";
    check1("txd", txd, 1'b1);
    check1("line_drive_en", line_drive_en, 1'b0);
    check1("tmt", tmt, 1'b1);
    check1("fifo_rd", fifo_rd, 1'b0);
    steps(4);

    // R2 R7 R9: single 8-bit frame, no parity, divisor 3
    cur_req = "R2";
    set_fmt(16'd3, 2'd3, 1'b0, 2'd0);
    push(8'hA5);
    drain();
    cur_req = "R9";
    push(8'h3C);
    drain();

    // R3: each shorter word length, upper bits must not appear
    cur_req = "R3";
    for (int w = 0; w < 3; w++) begin
      set_fmt(16'd2, 2'(w), 1'b0, 2'd0);
      push(8'hFF ^ 8'(w * 37));
      drain();
    end

    // R4: even, odd and the spare no-parity code
    cur_req = "R4";
    set_fmt(16'd2, 2'd2, 1'b0, 2'd1);
    push(8'h35);
    drain();
    set_fmt(16'd2, 2'd2, 1'b0, 2'd2);
    push(8'h35);
    drain();
    set_fmt(16'd2, 2'd0, 1'b0, 2'd2);
    push(8'h00);
    drain();
    set_fmt(16'd2, 2'd3, 1'b0, 2'd3);
    push(8'h81);
    drain();

    // R5: two stop bits
    cur_req = "R5";
    set_fmt(16'd3, 2'd3, 1'b1, 2'd1);
    push(8'h5A);
    drain();

    // R6: divisor zero behaves as one
    cur_req = "R6";
    set_fmt(16'd0, 2'd3, 1'b0, 2'd2);
    push(8'hC3);
    drain();
    set_fmt(16'd1, 2'd1, 1'b1, 2'd0);
    push(8'h2D);
    drain();

    // R8 R12: back-to-back characters, enable held, no lead between
    cur_req = "R8";
    set_fmt(16'd2, 2'd3, 1'b0, 2'd0);
    push(8'h11);
    push(8'h22);
    push(8'h33);
    drain();
    set_fmt(16'd0, 2'd0, 1'b1, 2'd1);
    push(8'h1F);
    push(8'h00);
    drain();

    // R12: push arrives while a frame is in flight
    cur_req = "R12";
    set_fmt(16'd2, 2'd3, 1'b0, 2'd0);
    push(8'h6E);
    steps(9);
    push(8'h91);
    drain();

    // R11: format and divisor change mid-frame, waiting character gets new format
    cur_req = "R11";
    set_fmt(16'd2, 2'd3, 1'b0, 2'd0);
    push(8'hB7);
    steps(6);
    set_fmt(16'd4, 2'd0, 1'b1, 2'd1);
    push(8'h4B);
    steps(3);
    set_fmt(16'd1, 2'd1, 1'b0, 2'd2);
    drain();

    // R10: idle flag with nothing queued
    cur_req = "R10";
    steps(3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    done = 1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      $display("FAIL watchdog expired during %s", cur_req);
      $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors + 1);
      $finish;
    end
  end
endmodule